// File: doc/BRIEF.md
# Firmware Flash Command-Mode Responder

This block models the command interface of a firmware flash device on a simple byte bus. The device has no address-specific command registers. A byte written to any address inside the device is a command. One command selects identification mode. Another returns the device to normal array reads, which is also the mode after reset. In identification mode the two lowest offsets return the manufacturer code and the device code. In array mode, reads return bytes from a small ROM stub whose contents are computed from the address.

Two configuration bytes sit in front of the device and control access to it. The first is a decode register: its top bit decides whether the device window answers at all. The second is a control byte holding a write-enable bit and a lock bit. The lock is sticky. Once set, it stops software from turning write enable back on, so command writes are ignored until reset. Software runs a probe in a fixed order: reset command, identification command, the two identification reads, then the reset command again. After that, array reads return normal contents.

Top module: `fwh_cmd_responder`

## Requirements
- R1: After reset the device is in array mode, both configuration bytes read 0x00 and `bus_rdata` is 0xFF.
- R2: In array mode with decode enabled, a read returns, on the clock edge that samples `bus_rd`, the byte (idx*29 + 0x5A) mod 256, where idx = `bus_addr` mod ROM_DEPTH (default 16).
- R3: An accepted write of 0x90 to any address switches the device to identification mode from the next cycle.
- R4: In identification mode, a read returns 0x89 at offset 0. At offset 1 it returns 0xAC when DEV_8MBIT=1 (the default) and 0xAD when DEV_8MBIT=0. At any other offset it returns 0x00.
- R5: An accepted write of 0xFF to any address returns the device to array mode. After the sequence 0xFF, 0x90, two identification reads, 0xFF, array reads return ROM contents again.
- R6: An accepted write of any byte other than 0xFF or 0x90 leaves the mode unchanged.
- R7: While bit 7 of the decode byte is 0, reads return 0xFF and bus writes do not change the mode.
- R8: While write enable (control bit 0) is 0, bus command writes are ignored and the mode is unchanged.
- R9: Lock (control bit 1) stays at 1 from the write that sets it until reset. While lock is 1, a control write cannot change write enable from 0 to 1, but it may clear write enable.
- R10: `cfg_sel`=0 selects the decode byte and `cfg_sel`=1 selects the control byte, for both `cfg_wr` and `cfg_rdata`. The control byte reads {6'b0, lock, write enable}, and its upper six bits are never stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_sel | input | 1 | 0 = decode byte, 1 = control byte |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Selected configuration byte (combinational) |
| bus_wr | input | 1 | Device window write strobe (command byte) |
| bus_rd | input | 1 | Device window read strobe |
| bus_addr | input | ADDR_W | Offset inside the device window |
| bus_wdata | input | 8 | Command byte |
| bus_rdata | output | 8 | Read data, registered, held between reads |

## Verification
Directed cases first check the reset values. They then run the full probe sequence, which separates the identification codes from the ROM bytes found at the same offsets. A command written while write enable is clear, while decode is off, and with an unknown value shows whether the mode moved: a read at offset 0 returns 0x89 in one mode and 0x5A in the other. A random phase then mixes configuration writes, command bytes weighted toward the two real commands, and reads across the whole address range. It compares each result against a bench model of mode, decode, write enable and lock. A final locked sequence tries to re-enable writing and checks, through readback and a later read, that the attempt had no effect.

// File: rtl/fwh_pkg.sv
package fwh_pkg;

   typedef enum logic {
      MODE_ARRAY = 1'b0,
      MODE_IDENT = 1'b1
   } fwh_mode_e;

   localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
   localparam logic [7:0] CMD_READ_IDENT = 8'h90;
   localparam logic [7:0] MFR_CODE       = 8'h89;
   localparam logic [7:0] DEV_CODE_8M    = 8'hAC;
   localparam logic [7:0] DEV_CODE_4M    = 8'hAD;
   localparam logic [7:0] FLOAT_BYTE     = 8'hFF;

   typedef struct packed {
      logic lock;
      logic wr_en;
   } fwh_ctrl_t;

endpackage

// File: rtl/fwh_cfg_regs.sv
module fwh_cfg_regs #(
   parameter int DEC_BIT = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic             cfg_sel,
   input  logic [7:0]       cfg_wdata,
   output logic [7:0]       cfg_rdata,
   output logic             dec_on,
   output fwh_pkg::fwh_ctrl_t ctrl
);
   import fwh_pkg::*;

   logic [7:0] dec_q;
   fwh_ctrl_t  ctrl_q;
   fwh_ctrl_t  ctrl_d;

   // write enable may always be cleared, but may only be raised while unlocked
   always_comb begin
      ctrl_d = ctrl_q;
      if (cfg_wr && cfg_sel) begin
         ctrl_d.lock  = ctrl_q.lock | cfg_wdata[1];
         ctrl_d.wr_en = ctrl_q.lock ? (ctrl_q.wr_en & cfg_wdata[0]) : cfg_wdata[0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_q  <= 8'h00;
         ctrl_q <= '0;
      end else begin
         if (cfg_wr && !cfg_sel) dec_q <= cfg_wdata;
         ctrl_q <= ctrl_d;
      end
   end

   assign cfg_rdata = cfg_sel ? {6'b0, ctrl_q.lock, ctrl_q.wr_en} : dec_q;
   assign dec_on    = dec_q[DEC_BIT];
   assign ctrl      = ctrl_q;

endmodule

// File: rtl/fwh_cmd_fsm.sv
module fwh_cmd_fsm (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_stb,
   input  logic [7:0]        cmd_byte,
   output fwh_pkg::fwh_mode_e mode
);
   import fwh_pkg::*;

   fwh_mode_e mode_q;
   fwh_mode_e mode_d;

   always_comb begin
      mode_d = mode_q;
      if (cmd_stb) begin
         unique case (cmd_byte)
            CMD_READ_ARRAY: mode_d = MODE_ARRAY;
            CMD_READ_IDENT: mode_d = MODE_IDENT;
            default:        mode_d = mode_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= MODE_ARRAY;
      else        mode_q <= mode_d;
   end

   assign mode = mode_q;

endmodule

// File: rtl/fwh_read_path.sv
module fwh_read_path #(
   parameter int ADDR_W    = 16,
   parameter int ROM_DEPTH = 16,
   parameter int ROM_MUL   = 29,
   parameter int ROM_ADD   = 90,
   parameter bit DEV_8MBIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   input  fwh_pkg::fwh_mode_e mode,
   input  logic              dec_on,
   output logic [7:0]        rdata
);
   import fwh_pkg::*;

   localparam int IDX_W = $clog2(ROM_DEPTH);

   logic [7:0] rom [ROM_DEPTH];
   logic [7:0] dev_code;
   logic [7:0] array_byte;
   logic [7:0] ident_byte;
   logic [7:0] rd_d;
   logic       off0;
   logic       off1;

   for (genvar gi = 0; gi < ROM_DEPTH; gi++) begin : g_rom
      assign rom[gi] = 8'((gi * ROM_MUL + ROM_ADD) % 256);
   end

   if (DEV_8MBIT) begin : g_dev8
      assign dev_code = DEV_CODE_8M;
   end else begin : g_dev4
      assign dev_code = DEV_CODE_4M;
   end

   assign array_byte = rom[addr[IDX_W-1:0]];
   assign off0       = (addr == ADDR_W'(0));
   assign off1       = (addr == ADDR_W'(1));
   assign ident_byte = off0 ? MFR_CODE : (off1 ? dev_code : 8'h00);

   always_comb begin
      if (!dec_on)                rd_d = FLOAT_BYTE;
      else if (mode == MODE_IDENT) rd_d = ident_byte;
      else                        rd_d = array_byte;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  rdata <= FLOAT_BYTE;
      else if (rd) rdata <= rd_d;
   end

endmodule

// File: rtl/fwh_cmd_responder.sv
module fwh_cmd_responder #(
   parameter int ADDR_W    = 16,
   parameter int ROM_DEPTH = 16,
   parameter int ROM_MUL   = 29,
   parameter int ROM_ADD   = 90,
   parameter bit DEV_8MBIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_sel,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_rdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata
);
   import fwh_pkg::*;

   localparam int DEC_BIT = 7;
   localparam int IDX_W   = $clog2(ROM_DEPTH);

   if (ROM_DEPTH < 2 || (ROM_DEPTH & (ROM_DEPTH - 1)) != 0) begin : g_bad_depth
      $fatal(1, "ROM_DEPTH must be a power of two of at least 2");
   end
   if (ADDR_W < IDX_W || ADDR_W < 2) begin : g_bad_addr
      $fatal(1, "ADDR_W too narrow for ROM_DEPTH");
   end

   logic      dec_on;
   fwh_ctrl_t ctrl;
   fwh_mode_e mode;
   logic      cmd_stb;

   fwh_cfg_regs #(.DEC_BIT(DEC_BIT)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .dec_on    (dec_on),
      .ctrl      (ctrl)
   );

   assign cmd_stb = bus_wr & dec_on & ctrl.wr_en;

   fwh_cmd_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_stb  (cmd_stb),
      .cmd_byte (bus_wdata),
      .mode     (mode)
   );

   fwh_read_path #(
      .ADDR_W    (ADDR_W),
      .ROM_DEPTH (ROM_DEPTH),
      .ROM_MUL   (ROM_MUL),
      .ROM_ADD   (ROM_ADD),
      .DEV_8MBIT (DEV_8MBIT)
   ) u_rd (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd     (bus_rd),
      .addr   (bus_addr),
      .mode   (mode),
      .dec_on (dec_on),
      .rdata  (bus_rdata)
   );

endmodule

// File: rtl/fwh_cmd_responder_chk.sv
module fwh_cmd_responder_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_wdata,
   input logic [7:0]        bus_rdata,
   input logic              dec_on,
   input logic              wr_en,
   input logic              lock,
   input logic              mode
);

   AST_DECODE_OFF_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !dec_on) |=> (bus_rdata == 8'hFF)); // R7

   AST_DECODE_OFF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !dec_on) |=> $stable(mode)); // R7

   AST_WRITE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !wr_en) |=> $stable(mode)); // R8

   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> lock); // R9

   AST_LOCK_HOLDS_WE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && !wr_en) |=> !wr_en); // R9

   AST_IDENT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && dec_on && wr_en && bus_wdata == 8'h90) |=> mode); // R3

   AST_ARRAY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && dec_on && wr_en && bus_wdata == 8'hFF) |=> !mode); // R5

   AST_MFR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && dec_on && mode && bus_addr == '0) |=> (bus_rdata == 8'h89)); // R4

   AST_OTHER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_wdata != 8'h90 && bus_wdata != 8'hFF) |=> $stable(mode)); // R6

endmodule

bind fwh_cmd_responder fwh_cmd_responder_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .dec_on    (dec_on),
   .wr_en     (ctrl.wr_en),
   .lock      (ctrl.lock),
   .mode      (mode)
);

// File: tb/tb_fwh_cmd_responder.sv
module tb_fwh_cmd_responder;

   localparam int ADDR_W = 16;
   localparam int DEPTH  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_wr = 1'b0;
   logic              cfg_sel = 1'b0;
   logic [7:0]        cfg_wdata = '0;
   logic [7:0]        cfg_rdata;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [7:0]        bus_wdata = '0;
   logic [7:0]        bus_rdata;

   int vectors = 0;
   int miscompares = 0;

   // bench model
   logic m_ident, m_we, m_lock;
   logic [7:0] m_dec;

   always #10 clk = ~clk;   // 50 MHz

   fwh_cmd_responder dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   function automatic logic [7:0] exp_read(logic [ADDR_W-1:0] a);
      if (!m_dec[7]) return 8'hFF;
      if (m_ident) begin
         if (a == 0) return 8'h89;
         if (a == 1) return 8'hAC;
         return 8'h00;
      end
      return 8'(((a % DEPTH) * 29 + 90) % 256);
   endfunction

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_ident = 1'b0; m_we = 1'b0; m_lock = 1'b0; m_dec = 8'h00;
   endtask

   task automatic cfg_write(logic sel, logic [7:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
      if (!sel) m_dec = d;
      else begin
         m_we   = m_lock ? (m_we & d[0]) : d[0];
         m_lock = m_lock | d[1];
      end
   endtask

   task automatic cfg_check(string req, logic sel);
      @(negedge clk);
      cfg_sel = sel;
      #1;
      check(req, cfg_rdata, sel ? {6'b0, m_lock, m_we} : m_dec);
   endtask

   task automatic cmd_write(logic [ADDR_W-1:0] a, logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      if (m_dec[7] && m_we) begin
         if (d == 8'hFF) m_ident = 1'b0;
         else if (d == 8'h90) m_ident = 1'b1;
      end
   endtask

   task automatic read_check(string req, logic [ADDR_W-1:0] a);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      check(req, bus_rdata, exp_read(a));
   endtask

   initial begin
      #4_000_000;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'd20240611;
      void'($urandom(seed));
      do_reset();
      // R1 reset state
      check("R1 rdata", bus_rdata, 8'hFF);
      cfg_check("R1 decode", 1'b0);
      cfg_check("R1 control", 1'b1);
      // R7 decode off: reads float, writes ignored
      read_check("R7 read", 16'h0003);
      cmd_write(16'h0040, 8'h90);
      cfg_write(1'b0, 8'h80);
      cfg_check("R10 decode readback", 1'b0);
      read_check("R2 array read", 16'h0000);
      // R8 writes disabled
      cmd_write(16'h0000, 8'h90);
      read_check("R8 mode held", 16'h0000);
      cfg_write(1'b1, 8'hFD);
      cfg_check("R10 control upper bits", 1'b1);
      // R3 R4 R5 probe sequence
      cmd_write(16'h1234, 8'hFF);
      cmd_write(16'h0007, 8'h90);
      read_check("R4 mfr", 16'h0000);
      read_check("R4 dev", 16'h0001);
      read_check("R4 other offset", 16'h0002);
      // R6 unknown command leaves ident mode
      cmd_write(16'h0000, 8'h12);
      read_check("R6 unknown cmd", 16'h0000);
      // R7 decode off in ident mode, write ignored
      cfg_write(1'b0, 8'h7F);
      read_check("R7 read ident", 16'h0000);
      cmd_write(16'h0000, 8'hFF);
      cfg_write(1'b0, 8'h80);
      read_check("R7 write ignored", 16'h0000);
      cmd_write(16'hFFFF, 8'hFF);
      read_check("R5 array restored", 16'h0000);
      read_check("R5 array restored", 16'h0001);
      read_check("R2 array wrap", 16'h0011);
      // random phase
      for (int i = 0; i < 1500; i++) begin
         int unsigned op;
         op = $urandom_range(0, 9);
         if (op == 0) begin
            logic [7:0] d;
            d = 8'($urandom());
            if ($urandom_range(0, 3) != 0) d[7] = 1'b1;
            cfg_write(1'b0, d);
         end else if (op == 1) begin
            logic [7:0] d;
            d = 8'($urandom());
            if ($urandom_range(0, 7) != 0) d[1] = 1'b0;
            cfg_write(1'b1, d);
            cfg_check("R9 random control", 1'b1);
         end else if (op < 5) begin
            logic [7:0] d;
            int unsigned k;
            k = $urandom_range(0, 3);
            d = (k == 0) ? 8'hFF : (k == 1) ? 8'h90 : 8'($urandom());
            cmd_write(16'($urandom()), d);
         end else begin
            logic [ADDR_W-1:0] a;
            a = ($urandom_range(0, 1) == 0) ? 16'($urandom_range(0, 3)) : 16'($urandom());
            read_check("R2 R4 random read", a);
         end
         if (m_lock && !m_we) begin
            do_reset();
            cfg_write(1'b0, 8'h80);
            cfg_write(1'b1, 8'h01);
         end
      end
      // R9 lock directed
      do_reset();
      cfg_write(1'b0, 8'h80);
      cfg_write(1'b1, 8'h01);
      cfg_write(1'b1, 8'h02);
      cfg_check("R9 lock clears we", 1'b1);
      cfg_write(1'b1, 8'h01);
      cfg_check("R9 we raise ignored", 1'b1);
      cmd_write(16'h0000, 8'h90);
      read_check("R9 cmd ignored while locked", 16'h0000);
      cfg_write(1'b1, 8'h00);
      cfg_check("R9 lock sticky", 1'b1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule